// File: doc/BRIEF.md
# Serial-Programmed Output Voltage Register

This block is the receive side of a two-wire serial bus that sets the output level of a programmable power converter. It watches the bus clock and data lines through synchronizers, spots start and stop conditions, and checks the first byte of each transfer against its own 7-bit address. A matching write is acknowledged. The slave then takes a word-address byte and any number of data bytes, and acknowledges each one in the ninth clock by pulling the data line low. The block never returns read data, so a read request is left unacknowledged.

Only word address zero holds state. It keeps a 6-bit level code in its low six bits. The word pointer steps by one after every data byte, so a second data byte in the same transfer lands on a location that does not exist: it is acknowledged and dropped. The stored code is clamped to the top step, then turned into a target voltage counted in 100 mV units. The range is 1.5 V at code zero up to 5.5 V at code 40. Every accepted write to the level register gives a one-cycle update pulse, so the regulator loop can load the new target.

Top module: `vreg_i2c_sink`

## Requirements
- R1: A transfer whose first byte is 0x10 (7-bit address 0x08 with the direction bit, bit 0, at 0) is acknowledged. The acknowledge is `sda_pull_o` high, which drives the data line low during the ninth clock.
- R2: A transfer whose first byte carries any other address is not acknowledged. The block then drives nothing until the next start or stop, and the stored code stays unchanged.
- R3: A first byte of 0x11 (matching address with the read bit set) is not acknowledged, and no data is ever driven.
- R4: After a matching address, the word-address byte and every data byte are acknowledged in their ninth clock. `sda_pull_o` is never high outside an acknowledge slot.
- R5: A data byte written to word address 0x00 stores its bits 5:0 on `level_o` and ignores bits 7:6. Each such write raises `update_o` for exactly one system clock cycle.
- R6: The word pointer advances by one after each data byte. Data for any word address other than 0x00 is acknowledged but changes neither `level_o` nor `update_o`.
- R7: `volt_o` equals 15 + min(`level_o`, 40), in 100 mV units. So code 0 gives 15, code 40 and above gives 55, and code 39 gives 54.
- R8: A start (data falling while the clock is high) begins a new address phase even in the middle of a transfer, which is a repeated start. A stop (data rising while the clock is high) ends the transfer and releases the line.
- R9: After reset, `sda_pull_o` is 0, `level_o` is 0, `volt_o` is 15 and `update_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least ten times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| level_o | output | 6 | Stored level code |
| volt_o | output | 6 | Target voltage in 100 mV units (15..55) |
| update_o | output | 1 | One-cycle pulse on each accepted level write |

## Verification
Two events can fall in the same system cycle. The eighth rising edge of a data byte stores the code and fires `update_o`, and the pointer step on that same edge decides where the next byte goes. The bench sends two data bytes back to back in one transfer. It expects the first value on `level_o` and counts exactly one update pulse, and the second byte still gets its acknowledge. A repeated start placed right after a refused address also shows that start detection wins over the idle skip state in that cycle, because the next address is then acknowledged.

// File: rtl/vreg_pkg.sv
`timescale 1ns/1ps
package vreg_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_ADDR,
      RX_WORD,
      RX_DATA,
      RX_SKIP
   } rx_state_t;
endpackage

// File: rtl/vreg_sync.sv
`timescale 1ns/1ps
module vreg_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] pipe [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("vreg_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[0] <= '1;
               else        pipe[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= '1;
               else        pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/vreg_bus_edge.sv
`timescale 1ns/1ps
module vreg_bus_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/vreg_rx_fsm.sv
`timescale 1ns/1ps
module vreg_rx_fsm
   import vreg_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR = 7'h08,
   parameter int unsigned CODE_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   output logic              ack_drv,
   output logic [CODE_W-1:0] code,
   output logic              upd
);
   localparam logic [7:0] WR_BYTE = {DEV_ADDR, 1'b0};

   rx_state_t  state;
   logic [7:0] shreg;
   logic [7:0] ptr;
   logic [3:0] bitcnt;
   logic       ack_pend;
   logic [7:0] new_byte;

   assign new_byte = {shreg[6:0], sda_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         shreg    <= '0;
         ptr      <= '0;
         bitcnt   <= '0;
         ack_pend <= 1'b0;
         ack_drv  <= 1'b0;
         code     <= '0;
         upd      <= 1'b0;
      end else begin
         upd <= 1'b0;
         if (start_det) begin
            state    <= RX_ADDR;
            bitcnt   <= '0;
            ack_pend <= 1'b0;
            ack_drv  <= 1'b0;
         end else if (stop_det) begin
            state    <= RX_IDLE;
            ack_pend <= 1'b0;
            ack_drv  <= 1'b0;
         end else if (state == RX_ADDR || state == RX_WORD || state == RX_DATA) begin
            if (scl_rise && !ack_drv && bitcnt < 4'd8) begin
               shreg  <= new_byte;
               bitcnt <= bitcnt + 4'd1;
               if (bitcnt == 4'd7) begin
                  unique case (state)
                     RX_ADDR: begin
                        if (new_byte == WR_BYTE) ack_pend <= 1'b1;
                        else                     state    <= RX_SKIP;
                     end
                     RX_WORD: begin
                        ptr      <= new_byte;
                        ack_pend <= 1'b1;
                     end
                     default: begin
                        if (ptr == 8'h00) begin
                           code <= new_byte[CODE_W-1:0];
                           upd  <= 1'b1;
                        end
                        ptr      <= ptr + 8'd1;
                        ack_pend <= 1'b1;
                     end
                  endcase
               end
            end else if (scl_fall && ack_pend) begin
               ack_pend <= 1'b0;
               ack_drv  <= 1'b1;
            end else if (scl_fall && ack_drv) begin
               ack_drv <= 1'b0;
               bitcnt  <= '0;
               if (state == RX_ADDR) state <= RX_WORD;
               else                  state <= RX_DATA;
            end
         end
      end
   end

   AST_UPD_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n)
                        upd |=> !upd); // R5
   AST_CODE_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
                        !upd |-> $stable(code)); // R5
   AST_START_FREE:   assert property (@(posedge clk) disable iff (!rst_n)
                        start_det |=> !ack_drv); // R8
   AST_DRV_IN_XFER:  assert property (@(posedge clk) disable iff (!rst_n)
                        ack_drv |-> (state != RX_IDLE && state != RX_SKIP)); // R2
endmodule

// File: rtl/vreg_level_map.sv
`timescale 1ns/1ps
module vreg_level_map #(
   parameter int unsigned CODE_W   = 6,
   parameter int unsigned VOLT_W   = 6,
   parameter int unsigned BASE     = 15,
   parameter int unsigned MAX_CODE = 40,
   parameter bit          CLAMP_EN = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   output logic [VOLT_W-1:0] volt
);
   localparam logic [CODE_W-1:0] MAX_C  = CODE_W'(MAX_CODE);
   localparam logic [VOLT_W-1:0] BASE_V = VOLT_W'(BASE);

   logic [CODE_W-1:0] lim;

   generate
      if (CLAMP_EN) begin : g_clamp
         assign lim = (code > MAX_C) ? MAX_C : code;
      end else begin : g_pass
         assign lim = code;
      end
   endgenerate

   assign volt = BASE_V + VOLT_W'(lim);
endmodule

// File: rtl/vreg_i2c_sink.sv
`timescale 1ns/1ps
module vreg_i2c_sink #(
   parameter logic [6:0]  DEV_ADDR    = 7'h08,
   parameter int unsigned CODE_W      = 6,
   parameter int unsigned VOLT_W      = 6,
   parameter int unsigned BASE        = 15,
   parameter int unsigned MAX_CODE    = 40,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   output logic [CODE_W-1:0] level_o,
   output logic [VOLT_W-1:0] volt_o,
   output logic              update_o
);
   localparam int unsigned TOP_V = BASE + MAX_CODE;

   generate
      if (TOP_V >= (1 << VOLT_W)) begin : g_vchk
         $error("volt_o too narrow for BASE + MAX_CODE");
      end
      if (MAX_CODE >= (1 << CODE_W)) begin : g_cchk
         $error("MAX_CODE does not fit the code width");
      end
   endgenerate

   logic [1:0] pins_s;
   logic       scl_rise, scl_fall, start_det, stop_det;

   vreg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(pins_s)
   );

   vreg_bus_edge u_edge (
      .clk(clk), .rst_n(rst_n), .scl_s(pins_s[1]), .sda_s(pins_s[0]),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   vreg_rx_fsm #(.DEV_ADDR(DEV_ADDR), .CODE_W(CODE_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .sda_s(pins_s[0]),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .ack_drv(sda_pull_o), .code(level_o), .upd(update_o)
   );

   vreg_level_map #(
      .CODE_W(CODE_W), .VOLT_W(VOLT_W), .BASE(BASE),
      .MAX_CODE(MAX_CODE), .CLAMP_EN(1'b1)
   ) u_map (
      .code(level_o), .volt(volt_o)
   );

   AST_VOLT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                      (volt_o >= VOLT_W'(BASE)) && (volt_o <= VOLT_W'(TOP_V))); // R7
   AST_ACK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
                      $rose(sda_pull_o) |-> $past(scl_fall)); // R4
endmodule

// File: tb/vreg_i2c_sink_bench.sv
`timescale 1ns/1ps
module vreg_i2c_sink_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_pull;
   logic [5:0] level;
   logic [5:0] volt;
   logic       update;
   logic       sda_bus;

   int checks = 0;
   int errors = 0;
   int upd_cnt = 0;
   int stray = 0;
   bit ack_win = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   assign sda_bus = sda_m & ~sda_pull;

   vreg_i2c_sink u_vreg_i2c_sink (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_pull_o(sda_pull), .level_o(level), .volt_o(volt), .update_o(update)
   );

   always @(negedge clk) begin
      if (rst_n && update) upd_cnt++;
      if (rst_n && sda_pull && !ack_win) stray++;
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic qtr();
      repeat (10) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; qtr();
      scl_m = 1'b1; qtr();
      sda_m = 1'b0; qtr();
      scl_m = 1'b0; qtr();
   endtask

   task automatic bus_stop();
      scl_m = 1'b0; sda_m = 1'b0; qtr();
      scl_m = 1'b1; qtr();
      sda_m = 1'b1; qtr();
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         qtr(); sda_m = b[i]; qtr();
         scl_m = 1'b1; qtr(); qtr();
         scl_m = 1'b0;
      end
      ack_win = 1'b1;
      qtr(); sda_m = 1'b1; qtr();
      scl_m = 1'b1; qtr();
      acked = !sda_bus;
      qtr();
      scl_m = 1'b0;
      qtr();
      ack_win = 1'b0;
   endtask

   task automatic write3(input logic [7:0] a, input logic [7:0] w, input logic [7:0] d,
                         output bit k0, output bit k1, output bit k2);
      bus_start();
      send_byte(a, k0);
      send_byte(w, k1);
      send_byte(d, k2);
      bus_stop();
   endtask

   task automatic t_reset();
      chk("R9 pull", int'(sda_pull), 0);
      chk("R9 level", int'(level), 0);
      chk("R9 volt", int'(volt), 15);
      chk("R9 update", int'(update), 0);
   endtask

   task automatic t_basic_write();
      bit k0, k1, k2;
      int u0 = upd_cnt;
      write3(8'h10, 8'h00, 8'h1A, k0, k1, k2);
      chk("R1 addr ack", int'(k0), 1);
      chk("R4 word ack", int'(k1), 1);
      chk("R4 data ack", int'(k2), 1);
      chk("R5 level", int'(level), 26);
      chk("R7 volt", int'(volt), 41);
      chk("R5 one pulse", upd_cnt - u0, 1);
   endtask

   task automatic t_wrong_addr();
      bit k0, k1, k2;
      int u0 = upd_cnt;
      write3(8'h12, 8'h00, 8'h05, k0, k1, k2);
      chk("R2 addr nack", int'(k0), 0);
      chk("R2 word nack", int'(k1), 0);
      chk("R2 data nack", int'(k2), 0);
      chk("R2 level kept", int'(level), 26);
      chk("R2 no pulse", upd_cnt - u0, 0);
   endtask

   task automatic t_read_req();
      bit k0, k1;
      bus_start();
      send_byte(8'h11, k0);
      send_byte(8'hFF, k1);
      bus_stop();
      chk("R3 read nack", int'(k0), 0);
      chk("R3 no drive", int'(k1), 0);
   endtask

   task automatic t_auto_inc();
      bit k0, k1, k2, k3;
      int u0 = upd_cnt;
      bus_start();
      send_byte(8'h10, k0);
      send_byte(8'h00, k1);
      send_byte(8'h05, k2);
      send_byte(8'h2A, k3);
      bus_stop();
      chk("R6 first ack", int'(k2), 1);
      chk("R6 second ack", int'(k3), 1);
      chk("R6 level first", int'(level), 5);
      chk("R6 one pulse", upd_cnt - u0, 1);
   endtask

   task automatic t_other_word();
      bit k0, k1, k2;
      int u0 = upd_cnt;
      write3(8'h10, 8'h01, 8'h09, k0, k1, k2);
      chk("R6 other ack", int'(k2), 1);
      chk("R6 other level", int'(level), 5);
      chk("R6 other no pulse", upd_cnt - u0, 0);
   endtask

   task automatic t_clamp();
      bit k0, k1, k2;
      write3(8'h10, 8'h00, 8'h3F, k0, k1, k2);
      chk("R7 code 63 level", int'(level), 63);
      chk("R7 code 63 volt", int'(volt), 55);
      write3(8'h10, 8'h00, 8'h28, k0, k1, k2);
      chk("R7 code 40 volt", int'(volt), 55);
      write3(8'h10, 8'h00, 8'h27, k0, k1, k2);
      chk("R7 code 39 volt", int'(volt), 54);
   endtask

   task automatic t_high_bits();
      bit k0, k1, k2;
      write3(8'h10, 8'h00, 8'hC3, k0, k1, k2);
      chk("R5 high bits ignored", int'(level), 3);
      chk("R7 code 3 volt", int'(volt), 18);
   endtask

   task automatic t_restart();
      bit k0, k1, k2, k3;
      bus_start();
      send_byte(8'h12, k0);
      sda_m = 1'b1; qtr();
      scl_m = 1'b1; qtr();
      sda_m = 1'b0; qtr();
      scl_m = 1'b0; qtr();
      send_byte(8'h10, k1);
      send_byte(8'h00, k2);
      send_byte(8'h07, k3);
      bus_stop();
      chk("R8 first nack", int'(k0), 0);
      chk("R8 restart ack", int'(k1), 1);
      chk("R8 level", int'(level), 7);
      qtr();
      chk("R8 released", int'(sda_pull), 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_basic_write();
      t_wrong_addr();
      t_read_req();
      t_auto_inc();
      t_other_word();
      t_clamp();
      t_high_bits();
      t_restart();
      chk("R4 no stray drive", stray, 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule